// File: doc/BRIEF.md
# Paired Add-Long SIMD Execution Unit

This unit executes one instruction of the pairwise add-long family on a 64-bit or 128-bit vector operand. It handles two forms. The plain form widens each pair of adjacent source elements to double width and adds them. The accumulating form then adds those paired sums, lane by lane, into the lanes already held in the destination register. Source elements are 8, 16 or 32 bits wide, chosen by the instruction's size field. Each result lane is twice that width, so the result has half as many lanes in the same total width.

A 32-bit instruction word is offered with a valid signal and is taken when the unit is ready. A word that belongs to neither form is refused and reported with a one-cycle foreign pulse. For an accepted word, the unit presents the source and destination register indices and waits for the read data. One cycle after the data is valid it pulses done. Along with done, it either raises the undefined flag or writes the result vector back with a write index and write enable. The destination register is only requested in the accumulating form.

Top module: `pal_unit`

## Requirements
- R1: A word is recognised when bits [31:23] are 111100111, bits [21:20] are 11, bits [17:16] are 00 and bit 4 is 0. Bits [11:8] must also be 0110 (accumulating) or 0010 (plain). Any other offered word is not accepted, and `foreign` pulses high in the next cycle with no read request.
- R2: For a 64-bit operand (Q = bit 6 = 0), the destination index is {bit 22, bits [15:12]} and the source index is {bit 5, bits [3:0]}.
- R3: For a 128-bit operand (Q=1), each index is that 5-bit value shifted right by one, with a zero upper bit.
- R4: A size field (bits [19:18]) of 3 makes the instruction undefined: `undef` pulses with done and `wr_en` stays low.
- R5: With Q=1, an odd Vd (bit 12) or an odd Vm (bit 0) makes the instruction undefined, with no write.
- R6: Bit 7 selects the extension of the source elements: 1 zero-extends them, 0 sign-extends them.
- R7: Source elements are 8 << size bits wide. Result lane i is the sum of widened source elements 2i and 2i+1, at twice the element width.
- R8: In the accumulating form, each paired sum is added to destination lane i, wrapping modulo the lane width without saturation, and `dst_rd` is high during the request. In the plain form, `dst_rd` is low and the destination data has no effect on the result.
- R9: With Q=0, only the low 64 bits carry lanes, `wr_data[127:64]` is zero and `wr_wide` is low. With Q=1, `wr_wide` is high.
- R10: `done` is a single-cycle pulse one cycle after the cycle in which `rd_req` and `rd_valid` are both high. `wr_idx` equals the destination index that was requested.
- R11: `insn_ready` is high in the done cycle, so a new word offered then is accepted and its read request follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Unit idle and able to take a word |
| foreign | output | 1 | Pulse: last offered word was not of this family |
| rd_req | output | 1 | Register read request |
| src_idx | output | 5 | Source register index |
| dst_idx | output | 5 | Destination register index |
| dst_rd | output | 1 | Destination register contents are needed |
| rd_valid | input | 1 | Read data valid |
| src_data | input | 128 | Source register contents |
| dst_data | input | 128 | Destination register contents |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined encoding, with done |
| wr_en | output | 1 | Result write enable, with done |
| wr_idx | output | 5 | Result register index |
| wr_wide | output | 1 | Result is a 128-bit operand |
| wr_data | output | 128 | Result vector |

## Verification
Completion of one instruction and acceptance of the next can fall in the same cycle, because the unit turns ready exactly as it pulses done. The bench provokes this by offering a second word at the moment the first result appears. It then judges both sides: the first result, index and flags must be correct in that cycle, and the second word's indices and read request must appear in the cycle that follows, without a gap.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } pal_state_e;

  typedef struct packed {
    logic             acc;    // accumulating form
    logic             uns;    // zero-extend sources
    logic             wide;   // 128-bit operand
    logic [1:0]       size;   // element size code
    logic [IDX_W-1:0] didx;   // destination index
    logic [IDX_W-1:0] sidx;   // source index
    logic             undef;  // undefined encoding
  } pal_op_t;

  // Fixed bits shared by both forms.
  function automatic logic pal_fixed_ok(input logic [INSN_W-1:0] w);
    return (w[31:23] == 9'b111100111) && (w[21:20] == 2'b11) &&
           (w[17:16] == 2'b00) && (w[4] == 1'b0);
  endfunction

  // Extend an element of esz bits held in v to 64 bits.
  function automatic logic [63:0] pal_widen(input logic [31:0] v,
                                            input int unsigned esz,
                                            input logic uns);
    logic [63:0] r;
    logic        fill;
    fill = uns ? 1'b0 : v[esz-1];
    r = {32'b0, v};
    for (int b = 0; b < 64; b++) begin
      if (b >= int'(esz)) r[b] = fill;
    end
    return r;
  endfunction

  // Paired sum with optional accumulate, 64-bit wide, caller truncates.
  function automatic logic [63:0] pal_lane(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input logic [63:0] prior,
                                           input int unsigned esz,
                                           input logic uns,
                                           input logic acc);
    logic [63:0] s;
    s = pal_widen(a, esz, uns) + pal_widen(b, esz, uns);
    if (acc) s = s + prior;
    return s;
  endfunction

endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output logic              hit,
  output pal_op_t           op
);

  logic             form_acc;
  logic             form_plain;
  logic [IDX_W-1:0] draw;
  logic [IDX_W-1:0] sraw;
  logic             wide;
  logic             bad_size;
  logic             bad_align;

  assign form_acc   = (word[11:8] == 4'b0110);
  assign form_plain = (word[11:8] == 4'b0010);
  assign hit        = pal_fixed_ok(word) && (form_acc || form_plain);

  assign draw = {word[22], word[15:12]};
  assign sraw = {word[5], word[3:0]};
  assign wide = word[6];

  assign bad_size  = (word[19:18] == 2'b11);
  assign bad_align = wide && (word[12] || word[0]);

  always_comb begin
    op.acc   = form_acc;
    op.uns   = word[7];
    op.wide  = wide;
    op.size  = word[19:18];
    op.didx  = wide ? {1'b0, draw[IDX_W-1:1]} : draw;
    op.sidx  = wide ? {1'b0, sraw[IDX_W-1:1]} : sraw;
    op.undef = bad_size || bad_align;
  end

endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [1:0]       size,
  input  logic             uns,
  input  logic             acc,
  input  logic             wide,
  output logic [VEC_W-1:0] res
);

  localparam int unsigned HALF_W = VEC_W / 2;
  localparam int unsigned N_SIZE = 3;

  logic [VEC_W-1:0] by_size [0:3];
  logic [VEC_W-1:0] picked;

  for (genvar gs = 0; gs < N_SIZE; gs++) begin : g_size
    localparam int unsigned ESZ = 8 << gs;
    localparam int unsigned LW  = 2 * ESZ;
    localparam int unsigned NL  = VEC_W / LW;
    logic [VEC_W-1:0] lanes;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      logic [63:0] full;
      assign full = pal_lane(32'(src[gl*LW +: ESZ]),
                             32'(src[gl*LW+ESZ +: ESZ]),
                             64'(dst[gl*LW +: LW]),
                             ESZ, uns, acc);
      assign lanes[gl*LW +: LW] = full[LW-1:0];
    end
    assign by_size[gs] = lanes;
  end

  assign by_size[3] = '0;
  assign picked     = by_size[size];
  assign res        = wide ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic             hit,
  input  pal_op_t          op_in,
  input  logic             rd_valid,
  input  logic [VEC_W-1:0] res,
  output logic             ready,
  output logic             accept_evt,
  output logic             finish_evt,
  output logic             rd_req,
  output pal_op_t          op_q,
  output logic             foreign,
  output logic             done,
  output logic             undef,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_wide,
  output logic [VEC_W-1:0] wr_data
);

  pal_state_e state;

  assign ready      = (state == ST_IDLE);
  assign rd_req     = (state == ST_READ);
  assign accept_evt = ready && insn_valid && hit;
  assign finish_evt = rd_req && rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      foreign <= 1'b0;
      done    <= 1'b0;
      undef   <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_wide <= 1'b0;
      wr_data <= '0;
    end else begin
      foreign <= ready && insn_valid && !hit;
      done    <= finish_evt;
      undef   <= finish_evt && op_q.undef;
      wr_en   <= finish_evt && !op_q.undef;
      if (accept_evt) begin
        op_q  <= op_in;
        state <= ST_READ;
      end else if (finish_evt) begin
        state   <= ST_IDLE;
        wr_idx  <= op_q.didx;
        wr_wide <= op_q.wide;
        wr_data <= op_q.undef ? '0 : res;
      end
    end
  end

endmodule

// File: rtl/pal_unit.sv
module pal_unit
  import pal_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn_word,
  output logic                 insn_ready,
  output logic                 foreign,
  output logic                 rd_req,
  output logic [IDX_W-1:0]     src_idx,
  output logic [IDX_W-1:0]     dst_idx,
  output logic                 dst_rd,
  input  logic                 rd_valid,
  input  logic [VEC_W-1:0]     src_data,
  input  logic [VEC_W-1:0]     dst_data,
  output logic                 done,
  output logic                 undef,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic                 wr_wide,
  output logic [VEC_W-1:0]     wr_data
);

  logic             dec_hit;
  pal_op_t          dec_op;
  pal_op_t          cur_op;
  logic             accept_evt;
  logic             finish_evt;
  logic [VEC_W-1:0] dp_res;

  pal_decode u_decode (
    .word (insn_word),
    .hit  (dec_hit),
    .op   (dec_op)
  );

  pal_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .hit        (dec_hit),
    .op_in      (dec_op),
    .rd_valid   (rd_valid),
    .res        (dp_res),
    .ready      (insn_ready),
    .accept_evt (accept_evt),
    .finish_evt (finish_evt),
    .rd_req     (rd_req),
    .op_q       (cur_op),
    .foreign    (foreign),
    .done       (done),
    .undef      (undef),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_wide    (wr_wide),
    .wr_data    (wr_data)
  );

  pal_datapath #(.VEC_W(VEC_W)) u_dp (
    .src  (src_data),
    .dst  (dst_data),
    .size (cur_op.size),
    .uns  (cur_op.uns),
    .acc  (cur_op.acc),
    .wide (cur_op.wide),
    .res  (dp_res)
  );

  assign src_idx = cur_op.sidx;
  assign dst_idx = cur_op.didx;
  assign dst_rd  = rd_req && cur_op.acc;

endmodule

// File: rtl/pal_unit_chk.sv
module pal_unit_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_ready,
  input logic             foreign,
  input logic             rd_req,
  input logic             rd_valid,
  input logic             dst_rd,
  input logic             done,
  input logic             undef,
  input logic             wr_en,
  input logic             wr_wide,
  input logic [VEC_W-1:0] wr_data,
  input logic             accept_evt,
  input logic             finish_evt
);

  localparam int unsigned HALF_W = VEC_W / 2;

  assert_done_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_write_on_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !wr_en);

  assert_outcome_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || undef) |-> done);

  assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |-> (wr_data[VEC_W-1:HALF_W] == '0));

  assert_foreign_no_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    foreign |-> !rd_req);

  assert_dst_read_in_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_rd |-> rd_req);

  assert_ready_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> insn_ready);

  assert_accept_starts_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> rd_req);

endmodule

bind pal_unit pal_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_ready (insn_ready),
  .foreign    (foreign),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .dst_rd     (dst_rd),
  .done       (done),
  .undef      (undef),
  .wr_en      (wr_en),
  .wr_wide    (wr_wide),
  .wr_data    (wr_data),
  .accept_evt (accept_evt),
  .finish_evt (finish_evt)
);

// File: tb/pal_unit_bench.sv
module pal_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VW         = 128;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          insn_valid = 1'b0;
  logic [31:0]   insn_word = '0;
  logic          insn_ready;
  logic          foreign;
  logic          rd_req;
  logic [4:0]    src_idx;
  logic [4:0]    dst_idx;
  logic          dst_rd;
  logic          rd_valid = 1'b0;
  logic [VW-1:0] src_data = '0;
  logic [VW-1:0] dst_data = '0;
  logic          done;
  logic          undef;
  logic          wr_en;
  logic [4:0]    wr_idx;
  logic          wr_wide;
  logic [VW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pal_unit u_pal_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .insn_ready(insn_ready), .foreign(foreign), .rd_req(rd_req),
    .src_idx(src_idx), .dst_idx(dst_idx), .dst_rd(dst_rd), .rd_valid(rd_valid),
    .src_data(src_data), .dst_data(dst_data), .done(done), .undef(undef),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic acc, input logic d, input logic [1:0] sz,
                                     input logic [3:0] vd, input logic op, input logic q,
                                     input logic m, input logic [3:0] vm);
    return {9'b111100111, d, 2'b11, sz, 2'b00, vd, (acc ? 4'b0110 : 4'b0010),
            op, q, m, 1'b0, vm};
  endfunction

  // Independent model: shift and mask per lane.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] s, input logic [VW-1:0] dd,
                                          input int sz, input logic uns, input logic acc,
                                          input logic q);
    logic [VW-1:0] r;
    logic [63:0]   emask;
    logic [63:0]   wmask;
    int e;
    int w;
    int n;
    r = '0;
    e = 8 << sz;
    w = 2 * e;
    n = (q ? 128 : 64) / w;
    emask = (64'd1 << e) - 64'd1;
    wmask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < n; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] t;
      a = 64'(s >> (2 * i * e)) & emask;
      b = 64'(s >> ((2 * i + 1) * e)) & emask;
      if (!uns && a[e-1]) a = a | ~emask;
      if (!uns && b[e-1]) b = b | ~emask;
      t = a + b;
      if (acc) t = t + 64'(dd >> (i * w));
      t = t & wmask;
      r = r | (VW'(t) << (i * w));
    end
    return r;
  endfunction

  // Offer a word at a falling edge; it is taken at the next rising edge.
  task automatic offer(input logic [31:0] w);
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = w;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  // Full sequence: request, data, completion, all checks.
  task automatic run_op(input string req, input logic acc, input logic d, input logic [1:0] sz,
                        input logic [3:0] vd, input logic op, input logic q,
                        input logic m, input logic [3:0] vm,
                        input logic [VW-1:0] s, input logic [VW-1:0] dd);
    logic [4:0] exp_d;
    logic [4:0] exp_s;
    logic       exp_undef;
    exp_d = q ? {1'b0, d, vd[3:1]} : {d, vd};
    exp_s = q ? {1'b0, m, vm[3:1]} : {m, vm};
    exp_undef = (sz == 2'b11) || (q && (vd[0] || vm[0]));
    offer(mk(acc, d, sz, vd, op, q, m, vm));
    check({req, " R2 R3 dst_idx"}, VW'(dst_idx), VW'(exp_d));
    check({req, " R2 R3 src_idx"}, VW'(src_idx), VW'(exp_s));
    check({req, " R8 dst_rd"}, VW'(dst_rd), VW'(acc));
    rd_valid = 1'b1;
    src_data = s;
    dst_data = dd;
    @(negedge clk);
    rd_valid = 1'b0;
    check({req, " R10 done"}, VW'(done), VW'(1));
    check({req, " R4 R5 undef"}, VW'(undef), VW'(exp_undef));
    check({req, " R4 R5 wr_en"}, VW'(wr_en), VW'(!exp_undef));
    if (!exp_undef) begin
      check({req, " R10 wr_idx"}, VW'(wr_idx), VW'(exp_d));
      check({req, " R9 wr_wide"}, VW'(wr_wide), VW'(q));
      check({req, " R6 R7 R8 wr_data"}, wr_data, model(s, dd, int'(sz), op, acc, q));
    end
    @(negedge clk);
    check({req, " R10 done single"}, VW'(done), VW'(0));
  endtask

  task automatic t_reset();
    check("R10 reset done", VW'(done), VW'(0));
    check("R10 reset wr_en", VW'(wr_en), VW'(0));
    check("R11 reset ready", VW'(insn_ready), VW'(1));
    check("R1 reset rd_req", VW'(rd_req), VW'(0));
  endtask

  task automatic t_foreign();
    logic [31:0] w;
    w = mk(1'b0, 1'b0, 2'b00, 4'd2, 1'b0, 1'b0, 1'b0, 4'd4);
    w[11:8] = 4'b0111;
    offer(w);
    check("R1 foreign pulse", VW'(foreign), VW'(1));
    check("R1 no request", VW'(rd_req), VW'(0));
    w = mk(1'b1, 1'b0, 2'b00, 4'd2, 1'b0, 1'b0, 1'b0, 4'd4);
    w[4] = 1'b1;
    offer(w);
    check("R1 foreign bit4", VW'(foreign), VW'(1));
    @(negedge clk);
    check("R1 foreign single", VW'(foreign), VW'(0));
  endtask

  task automatic t_back_to_back();
    logic [VW-1:0] s1;
    s1 = {64'h0, 64'h0102_0304_F0F0_8081};
    offer(mk(1'b0, 1'b1, 2'b00, 4'd3, 1'b1, 1'b0, 1'b0, 4'd5));
    rd_valid = 1'b1;
    src_data = s1;
    @(negedge clk);
    rd_valid = 1'b0;
    // completion cycle: offer the next word now
    check("R11 ready during done", VW'(insn_ready), VW'(1));
    check("R11 first result", wr_data, model(s1, '0, 0, 1'b1, 1'b0, 1'b0));
    check("R11 first wr_idx", VW'(wr_idx), VW'(5'h13));
    insn_valid = 1'b1;
    insn_word  = mk(1'b1, 1'b0, 2'b01, 4'd6, 1'b0, 1'b1, 1'b1, 4'd8);
    @(negedge clk);
    insn_valid = 1'b0;
    check("R11 second request", VW'(rd_req), VW'(1));
    check("R11 second dst_idx", VW'(dst_idx), VW'(5'd3));
    check("R11 second src_idx", VW'(src_idx), VW'(5'd12));
    check("R11 done dropped", VW'(done), VW'(0));
    rd_valid = 1'b1;
    src_data = 128'h8000_7FFF_FFFF_0001_1234_EDCB_0002_FFFE;
    dst_data = 128'h0000_0001_FFFF_FFFF_7FFF_FFFF_0000_0010;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R11 second result", wr_data,
          model(128'h8000_7FFF_FFFF_0001_1234_EDCB_0002_FFFE,
                128'h0000_0001_FFFF_FFFF_7FFF_FFFF_0000_0010, 1, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    // R7 R6: plain, signed bytes, wide
    run_op("plain s8 q", 1'b0, 1'b0, 2'b00, 4'd4, 1'b0, 1'b1, 1'b1, 4'd6,
           128'h80FF_7F01_0203_FEFD_807F_FF00_1122_C3D4, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    // R6: same data unsigned
    run_op("plain u8 q", 1'b0, 1'b0, 2'b00, 4'd4, 1'b1, 1'b1, 1'b1, 4'd6,
           128'h80FF_7F01_0203_FEFD_807F_FF00_1122_C3D4, '0);
    // R8 R9: accumulate unsigned 16-bit narrow, upper source ignored
    run_op("acc u16 d", 1'b1, 1'b1, 2'b01, 4'd9, 1'b1, 1'b0, 1'b0, 4'd3,
           128'hDEAD_BEEF_DEAD_BEEF_FFFF_FFFF_1234_8000, 128'h5555_5555_5555_5555_FFFF_FFF0_0000_0100);
    // R8 wrap: signed 32-bit accumulate
    run_op("acc s32 wrap", 1'b1, 1'b0, 2'b10, 4'd0, 1'b0, 1'b1, 1'b0, 4'd2,
           128'h8000_0000_8000_0000_7FFF_FFFF_7FFF_FFFF, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF);
    // R7: unsigned 32-bit plain narrow
    run_op("plain u32 d", 1'b0, 1'b1, 2'b10, 4'd15, 1'b1, 1'b0, 1'b1, 4'd15,
           128'h0, 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF);
    // R4: size 3
    run_op("undef size", 1'b1, 1'b0, 2'b11, 4'd2, 1'b0, 1'b0, 1'b0, 4'd2, '1, '1);
    // R5: odd Vd with wide operand
    run_op("undef odd vd", 1'b0, 1'b0, 2'b01, 4'd5, 1'b0, 1'b1, 1'b0, 4'd2, '1, '0);
    // R5: odd Vm with wide operand
    run_op("undef odd vm", 1'b1, 1'b1, 2'b00, 4'd2, 1'b1, 1'b1, 1'b1, 4'd7, '1, '0);
    t_foreign();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule